// File: doc/BRIEF.md
# Far Control Transfer Privilege Checker

This block rules on one far control transfer at a time in a four-ring protection scheme. Rings are numbered 0 to 3, and 0 is the most privileged. A transfer is one of these: a jump, a call, a return, an interrupt return, a software interrupt, an exception or an external interrupt. The caller supplies several fields, all already decoded from the selector and the descriptor:

- the current ring;
- the requested ring carried by the selector;
- the descriptor table the selector points into;
- the descriptor class and its privilege level;
- the conforming attribute;
- for gates, the privilege level and conforming attribute of the code segment the gate names;
- the nested-task flag.

The block first checks that the descriptor class and the table are legal for the operation. It then applies the ring rule of the chosen path: direct code, gate, return or task switch.

The verdict is registered and appears exactly one clock after the request strobe. It consists of an allow bit, a protection-fault vector and error code, a classification of the path, and the ring the transfer leaves the processor in. There is no back-pressure. The block accepts a request in every cycle its strobe is high, and each result is valid for the single cycle after its request. Fetching descriptors, switching stacks and saving or restoring task state all happen outside this block.

Top module: `xfer_guard`

## Requirements
- R1: `res_valid_o` is high in exactly the cycle after each cycle in which `req_valid_i` is high, and low otherwise. There is no ready signal, and back-to-back requests each get their own result.
- R2: After reset, and until the first result, `res_valid_o`, `allow_o`, `fault_vec_o`, `err_code_o`, `class_o` and `new_cpl_o` are all zero.
- R3: The encodings are as follows.
  - Operations: 0 jump, 1 call, 2 return, 3 interrupt return, 4 software interrupt, 5 exception, 6 external interrupt, 7 illegal.
  - Tables: 0 global, 1 local, 2 interrupt, 3 illegal.
  - Descriptor classes: 0 code, 1 call gate, 2 trap gate, 3 interrupt gate, 4 task gate, 5 task-state segment, 6 and 7 illegal.

  A jump or a call is legal with a code descriptor or a task gate from the global or local table, or with a task-state segment from the global table. A call may also use a call gate from the global or local table. Every other combination faults, and so does operation 7.
- R4: A return, and an interrupt return with the nested flag clear, needs a code descriptor from the global or local table. An interrupt return with the nested flag set needs a task-state segment from the global table. Any other combination faults.
- R5: The three interrupt operations need a trap gate, an interrupt gate or a task gate from the interrupt table. Table 3, or any table other than the interrupt table, faults.
- R6: A direct code path (class 1) to non-conforming code needs DPL equal to CPL. To conforming code it needs DPL numerically less than or equal to CPL. The new CPL is the current CPL.
- R7: A gate path (class 2), taken by a call gate, trap gate or interrupt gate, needs three conditions: RPL ≤ gate DPL, CPL ≤ gate DPL, and gate-target DPL ≤ CPL, all compared numerically. The new CPL is the target DPL when the target is non-conforming, and the current CPL otherwise.
- R8: A return path (class 3) needs RPL ≥ CPL. The target must be non-conforming code with DPL equal to RPL, or conforming code with DPL ≤ RPL. The new CPL is the RPL.
- R9: A task-switch path (class 4), through a task gate or a task-state segment, needs the descriptor DPL ≥ CPL. The new CPL output is the current CPL.
- R10: When a transfer is refused, the result carries the following.
  - `allow_o`=0, `fault_vec_o`=13 and `class_o`=0.
  - `new_cpl_o` equal to the current CPL.
  - `err_code_o` = {selector index, table code, ext}, where ext is 1 for an exception or external interrupt.

  When a transfer is allowed, the fault vector and the error code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one transfer per high cycle |
| op_i | input | 3 | Operation code |
| cpl_i | input | 2 | Current privilege ring |
| rpl_i | input | 2 | Requested ring from the selector |
| sel_index_i | input | IDX_W (13) | Selector index, copied into the error code |
| table_i | input | 2 | Table code of the selector |
| dtype_i | input | 3 | Descriptor class |
| ddpl_i | input | 2 | Descriptor privilege level |
| dconf_i | input | 1 | Descriptor conforming attribute |
| tgt_dpl_i | input | 2 | DPL of the code segment named by a gate |
| tgt_conf_i | input | 1 | Conforming attribute of the gate's code segment |
| nested_i | input | 1 | Nested-task flag |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| allow_o | output | 1 | Transfer permitted |
| fault_vec_o | output | 8 | 13 on refusal, else 0 |
| err_code_o | output | IDX_W+3 (16) | Fault error code |
| class_o | output | 3 | Path class 0 to 4 |
| new_cpl_o | output | 2 | Ring after the transfer |

## Verification
The hardest case to reach from the ports is an allowed inward gate transfer. It needs the right operation, the right class and the right table at once. On top of that, RPL and CPL must both sit at or below the gate DPL while the target DPL is no higher than CPL. Uniform random inputs almost never line all of that up. The stimulus therefore biases most transactions toward a legal class and table for the chosen operation, and leaves privilege levels uniform so that each ring relation is crossed often. Directed cases pin down the inward call to ring 0, the jump through a call gate, the nested interrupt return through a local table, and the reserved table.

// File: rtl/xfer_guard_pkg.sv
package xfer_guard_pkg;
  typedef enum logic [2:0] {
    OP_JMP = 3'd0, OP_CALL = 3'd1, OP_RET = 3'd2, OP_IRET = 3'd3,
    OP_SWINT = 3'd4, OP_EXC = 3'd5, OP_EXTINT = 3'd6, OP_ILL = 3'd7
  } xop_e;

  typedef enum logic [1:0] {
    TB_GLOBAL = 2'd0, TB_LOCAL = 2'd1, TB_INTR = 2'd2, TB_ILL = 2'd3
  } tbl_e;

  typedef enum logic [2:0] {
    DT_CODE = 3'd0, DT_CALLGATE = 3'd1, DT_TRAPGATE = 3'd2, DT_INTGATE = 3'd3,
    DT_TASKGATE = 3'd4, DT_TSS = 3'd5, DT_ILL6 = 3'd6, DT_ILL7 = 3'd7
  } dtype_e;

  typedef enum logic [2:0] {
    PATH_BAD = 3'd0, PATH_DIRECT = 3'd1, PATH_GATE = 3'd2,
    PATH_RETURN = 3'd3, PATH_TASK = 3'd4
  } path_e;

  localparam logic [7:0] GP_VECTOR = 8'd13;
endpackage

// File: rtl/xfer_type_sel.sv
module xfer_type_sel
  import xfer_guard_pkg::*;
(
  input  xop_e   op,
  input  tbl_e   tbl,
  input  dtype_e dtype,
  input  logic   nested,
  output path_e  path
);
  logic seg_tbl;
  assign seg_tbl = (tbl == TB_GLOBAL) || (tbl == TB_LOCAL);

  always_comb begin
    path = PATH_BAD;
    case (op)
      OP_JMP, OP_CALL: begin
        if (seg_tbl) begin
          case (dtype)
            DT_CODE:     path = PATH_DIRECT;
            DT_CALLGATE: path = (op == OP_CALL) ? PATH_GATE : PATH_BAD;
            DT_TASKGATE: path = PATH_TASK;
            DT_TSS:      path = (tbl == TB_GLOBAL) ? PATH_TASK : PATH_BAD;
            default:     path = PATH_BAD;
          endcase
        end
      end
      OP_RET: begin
        if (seg_tbl && dtype == DT_CODE) path = PATH_RETURN;
      end
      OP_IRET: begin
        if (nested) begin
          if (tbl == TB_GLOBAL && dtype == DT_TSS) path = PATH_TASK;
        end else if (seg_tbl && dtype == DT_CODE) begin
          path = PATH_RETURN;
        end
      end
      OP_SWINT, OP_EXC, OP_EXTINT: begin
        if (tbl == TB_INTR) begin
          case (dtype)
            DT_TRAPGATE, DT_INTGATE: path = PATH_GATE;
            DT_TASKGATE:             path = PATH_TASK;
            default:                 path = PATH_BAD;
          endcase
        end
      end
      default: path = PATH_BAD;
    endcase
  end
endmodule

// File: rtl/xfer_ring_chk.sv
module xfer_ring_chk
  import xfer_guard_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  path_e            path,
  input  logic [PL_W-1:0]  cpl,
  input  logic [PL_W-1:0]  rpl,
  input  logic [PL_W-1:0]  ddpl,
  input  logic             dconf,
  input  logic [PL_W-1:0]  tgt_dpl,
  input  logic             tgt_conf,
  output logic             ok,
  output logic [PL_W-1:0]  new_cpl
);
  logic direct_ok, gate_ok, ret_ok, task_ok;

  assign direct_ok = dconf ? (ddpl <= cpl) : (ddpl == cpl);
  assign gate_ok   = (rpl <= ddpl) && (cpl <= ddpl) && (tgt_dpl <= cpl);
  assign ret_ok    = (rpl >= cpl) && (dconf ? (ddpl <= rpl) : (ddpl == rpl));
  assign task_ok   = (ddpl >= cpl);

  always_comb begin
    ok      = 1'b0;
    new_cpl = cpl;
    case (path)
      PATH_DIRECT: ok = direct_ok;
      PATH_GATE: begin
        ok      = gate_ok;
        new_cpl = tgt_conf ? cpl : tgt_dpl;
      end
      PATH_RETURN: begin
        ok      = ret_ok;
        new_cpl = rpl;
      end
      PATH_TASK: ok = task_ok;
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/xfer_guard.sv
module xfer_guard
  import xfer_guard_pkg::*;
#(
  parameter int IDX_W = 13,
  parameter int PL_W  = 2,
  localparam int ERR_W = IDX_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [2:0]       op_i,
  input  logic [PL_W-1:0]  cpl_i,
  input  logic [PL_W-1:0]  rpl_i,
  input  logic [IDX_W-1:0] sel_index_i,
  input  logic [1:0]       table_i,
  input  logic [2:0]       dtype_i,
  input  logic [PL_W-1:0]  ddpl_i,
  input  logic             dconf_i,
  input  logic [PL_W-1:0]  tgt_dpl_i,
  input  logic             tgt_conf_i,
  input  logic             nested_i,
  output logic             res_valid_o,
  output logic             allow_o,
  output logic [7:0]       fault_vec_o,
  output logic [ERR_W-1:0] err_code_o,
  output logic [2:0]       class_o,
  output logic [PL_W-1:0]  new_cpl_o
);
  path_e           path;
  logic            ring_ok;
  logic [PL_W-1:0] ring_cpl;
  logic            grant;
  logic            ext_src;

  xfer_type_sel u_type (
    .op     (xop_e'(op_i)),
    .tbl    (tbl_e'(table_i)),
    .dtype  (dtype_e'(dtype_i)),
    .nested (nested_i),
    .path   (path)
  );

  xfer_ring_chk #(.PL_W(PL_W)) u_ring (
    .path     (path),
    .cpl      (cpl_i),
    .rpl      (rpl_i),
    .ddpl     (ddpl_i),
    .dconf    (dconf_i),
    .tgt_dpl  (tgt_dpl_i),
    .tgt_conf (tgt_conf_i),
    .ok       (ring_ok),
    .new_cpl  (ring_cpl)
  );

  assign grant   = (path != PATH_BAD) && ring_ok;
  assign ext_src = (op_i == OP_EXC) || (op_i == OP_EXTINT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      allow_o     <= 1'b0;
      fault_vec_o <= '0;
      err_code_o  <= '0;
      class_o     <= '0;
      new_cpl_o   <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        allow_o     <= grant;
        fault_vec_o <= grant ? 8'd0 : GP_VECTOR;
        err_code_o  <= grant ? '0 : {sel_index_i, table_i, ext_src};
        class_o     <= grant ? path : PATH_BAD;
        new_cpl_o   <= grant ? ring_cpl : cpl_i;
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> res_valid_o);  // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !res_valid_o);  // R1
  AST_RET_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i == OP_RET) |-> (path == PATH_BAD || path == PATH_RETURN));  // R4
  AST_GATE_NO_OUTWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && allow_o && class_o == PATH_GATE) |-> (new_cpl_o <= $past(cpl_i)));  // R7
  AST_RETURN_NO_INWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && allow_o && class_o == PATH_RETURN) |-> (new_cpl_o >= $past(cpl_i)));  // R8
  AST_FAULT_KEEPS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !allow_o) |->
      (new_cpl_o == $past(cpl_i) && err_code_o[ERR_W-1:3] == $past(sel_index_i)));  // R10
endmodule

// File: tb/test_xfer_guard.sv
module test_xfer_guard;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 13;
  localparam int ERR_W = IDX_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [1:0] cpl_i = '0, rpl_i = '0, ddpl_i = '0, tgt_dpl_i = '0, table_i = '0;
  logic [IDX_W-1:0] sel_index_i = '0;
  logic [2:0] dtype_i = '0;
  logic dconf_i = 1'b0, tgt_conf_i = 1'b0, nested_i = 1'b0;
  logic res_valid_o, allow_o;
  logic [7:0] fault_vec_o;
  logic [ERR_W-1:0] err_code_o;
  logic [2:0] class_o;
  logic [1:0] new_cpl_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_guard i_xfer_guard (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .op_i(op_i),
    .cpl_i(cpl_i), .rpl_i(rpl_i), .sel_index_i(sel_index_i), .table_i(table_i),
    .dtype_i(dtype_i), .ddpl_i(ddpl_i), .dconf_i(dconf_i), .tgt_dpl_i(tgt_dpl_i),
    .tgt_conf_i(tgt_conf_i), .nested_i(nested_i), .res_valid_o(res_valid_o),
    .allow_o(allow_o), .fault_vec_o(fault_vec_o), .err_code_o(err_code_o),
    .class_o(class_o), .new_cpl_o(new_cpl_o)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference rules written from the requirements.
  function automatic void model(input int op, input int cpl, input int rpl, input int tbl,
                                input int dt, input int dpl, input bit conf, input int tdpl,
                                input bit tconf, input bit nt, output bit ok, output int cls,
                                output int ncpl, output string tag);
    bit seg;
    seg = (tbl == 0 || tbl == 1);
    ok = 0; cls = 0; ncpl = cpl; tag = "R3";
    if (op == 0 || op == 1) begin
      tag = "R3";
      if (seg && dt == 0) begin
        tag = "R6"; ok = conf ? (dpl <= cpl) : (dpl == cpl); cls = 1;
      end else if (seg && dt == 1 && op == 1) begin
        tag = "R7"; ok = (rpl <= dpl) && (cpl <= dpl) && (tdpl <= cpl); cls = 2;
        if (ok && !tconf) ncpl = tdpl;
      end else if ((seg && dt == 4) || (tbl == 0 && dt == 5)) begin
        tag = "R9"; ok = (dpl >= cpl); cls = 4;
      end
    end else if (op == 2 || (op == 3 && !nt)) begin
      tag = "R4";
      if (seg && dt == 0) begin
        tag = "R8"; cls = 3;
        ok = (rpl >= cpl) && (conf ? (dpl <= rpl) : (dpl == rpl));
        if (ok) ncpl = rpl;
      end
    end else if (op == 3) begin
      tag = "R4";
      if (tbl == 0 && dt == 5) begin tag = "R9"; ok = (dpl >= cpl); cls = 4; end
    end else if (op >= 4 && op <= 6) begin
      tag = "R5";
      if (tbl == 2 && (dt == 2 || dt == 3)) begin
        tag = "R7"; ok = (rpl <= dpl) && (cpl <= dpl) && (tdpl <= cpl); cls = 2;
        if (ok && !tconf) ncpl = tdpl;
      end else if (tbl == 2 && dt == 4) begin
        tag = "R9"; ok = (dpl >= cpl); cls = 4;
      end
    end
    if (!ok) begin cls = 0; ncpl = cpl; end
  endfunction

  task automatic run_one(input int op, input int cpl, input int rpl, input int tbl,
                         input int dt, input int dpl, input bit conf, input int tdpl,
                         input bit tconf, input bit nt, input int idx);
    bit eok; int ecls, encpl; string tag;
    longint eerr;
    model(op, cpl, rpl, tbl, dt, dpl, conf, tdpl, tconf, nt, eok, ecls, encpl, tag);
    eerr = eok ? 0 : ((longint'(idx) << 3) | (longint'(tbl) << 1) | ((op == 5 || op == 6) ? 1 : 0));
    @(negedge clk);
    req_valid_i = 1'b1;
    op_i = op[2:0]; cpl_i = cpl[1:0]; rpl_i = rpl[1:0]; table_i = tbl[1:0];
    dtype_i = dt[2:0]; ddpl_i = dpl[1:0]; dconf_i = conf; tgt_dpl_i = tdpl[1:0];
    tgt_conf_i = tconf; nested_i = nt; sel_index_i = idx[IDX_W-1:0];
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R1", res_valid_o == 1'b1, "res_valid", res_valid_o, 1);
    check(tag, allow_o == eok, "allow", allow_o, eok);
    check(tag, class_o == ecls[2:0], "class", class_o, ecls);
    check(tag, new_cpl_o == encpl[1:0], "new_cpl", new_cpl_o, encpl);
    check("R10", fault_vec_o == (eok ? 8'd0 : 8'd13), "fault_vec", fault_vec_o, eok ? 0 : 13);
    check("R10", err_code_o == eerr[ERR_W-1:0], "err_code", err_code_o, eerr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    #(CLK_PERIOD * 2 + 1);
    // R2: reset values
    check("R2", res_valid_o == 0 && allow_o == 0 && class_o == 0, "rst ctl",
          {res_valid_o, allow_o, class_o}, 0);
    check("R2", fault_vec_o == 0 && err_code_o == 0 && new_cpl_o == 0, "rst data",
          err_code_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R2", res_valid_o == 0, "idle after reset", res_valid_o, 0);

    // Directed corner cases
    run_one(0, 3, 3, 0, 1, 3, 0, 0, 0, 0, 11);   // R3 jump through call gate faults
    run_one(1, 3, 3, 1, 1, 3, 0, 0, 0, 0, 12);   // R7 inward call to ring 0
    run_one(1, 2, 2, 0, 1, 1, 0, 0, 0, 0, 13);   // R7 CPL above gate DPL faults
    run_one(0, 2, 0, 0, 0, 1, 1, 0, 0, 0, 14);   // R6 conforming jump
    run_one(0, 2, 0, 0, 0, 1, 0, 0, 0, 0, 15);   // R6 non-conforming DPL mismatch
    run_one(2, 0, 3, 1, 0, 3, 0, 0, 0, 0, 16);   // R8 return to ring 3
    run_one(2, 2, 1, 0, 0, 1, 0, 0, 0, 0, 17);   // R8 inward return faults
    run_one(3, 0, 0, 1, 5, 3, 0, 0, 0, 1, 18);   // R4 nested iret via local table
    run_one(3, 0, 0, 0, 5, 3, 0, 0, 0, 1, 19);   // R9 nested iret task switch
    run_one(5, 3, 0, 3, 3, 3, 0, 0, 0, 0, 8191); // R5 reserved table, ext bit
    run_one(4, 3, 3, 2, 3, 3, 0, 0, 0, 0, 20);   // R7 software interrupt gate
    run_one(1, 2, 2, 0, 5, 1, 0, 0, 0, 0, 21);   // R9 task DPL below CPL faults
    run_one(6, 0, 0, 2, 4, 0, 0, 0, 0, 0, 22);   // R9 external interrupt task gate
    run_one(1, 1, 1, 1, 5, 3, 0, 0, 0, 0, 23);   // R3 TSS in local table faults
    @(negedge clk);
    check("R1", res_valid_o == 0, "no result without request", res_valid_o, 0);

    // Biased random stimulus
    for (int i = 0; i < 3000; i++) begin
      int op, tbl, dt;
      op = int'($urandom % 8);
      tbl = int'($urandom % 4);
      dt = int'($urandom % 8);
      if (($urandom % 10) < 7) begin
        if (op <= 1) begin
          tbl = int'($urandom % 2);
          dt = (($urandom % 2) == 0) ? int'($urandom % 2) : 4 + int'($urandom % 2);
        end else if (op <= 3) begin
          tbl = int'($urandom % 2);
          dt = (($urandom % 3) == 0) ? 5 : 0;
        end else if (op <= 6) begin
          tbl = 2;
          dt = 2 + int'($urandom % 3);
        end
      end
      run_one(op, int'($urandom % 4), int'($urandom % 4), tbl, dt, int'($urandom % 4),
              1'($urandom % 2), int'($urandom % 4), 1'($urandom % 2),
              1'($urandom % 2), int'($urandom % 8192));
    end
    @(negedge clk);
    check("R1", res_valid_o == 0, "result drops after last", res_valid_o, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule